// File: doc/BRIEF.md
# Cache Access Sequencer with Line Fill

This block stands between a processor request port and a master port on the internal system bus. It owns a small direct-mapped cache of four-longword lines. It also decides, from the top two address bits, whether each request goes to the cacheable space, to the uncached (cache-through) space or to the peripheral space. Cacheable reads spend one cycle on the tag compare. A hit is answered at once. A miss loads the line with four longword reads at increasing addresses. If the victim line is dirty, it is first written back as four longword writes.

Writes follow one of two policies, chosen by a mode input. In write-through mode a hit updates the cached word and the same write also goes to the bus. In write-back mode a hit only updates the line and marks it dirty, and memory sees the data when that line is later evicted or flushed. A write miss never allocates a line. A flush input walks every index, invalidates each line and, in write-back mode, first writes back any dirty line. Software uses the flush to keep the cache coherent with other bus masters.

On the processor side each request is held until a single-cycle acknowledge. On the bus side each beat is held until the bus acknowledges it.

Top module: `cache_seq`

## Requirements
- R1: Address bits [31:30] select the space: 00 cacheable, 01 cache-through, 10 and 11 peripheral. Only the cacheable space is ever looked up or filled.
- R2: A cacheable read that hits is acknowledged in the cycle after the request is taken (latency 1). It returns the cached longword that holds the address and makes no bus beat.
- R3: A cacheable read miss issues four read beats of size 2 (longword) at the line base, then +4, +8 and +12. It then returns the requested longword, and a later read to that line hits.
- R4: Fill beats are longword-sized and start at the line base even when the missing request is a byte (size 0), a halfword (size 1) or a fetch at an address of the form 4n+2.
- R5: A read to the cache-through or peripheral space spends one decode cycle before a single bus read at the requested address and size (0 byte, 1 halfword, 2 longword). The bus data is returned, so with a zero-wait bus the latency is 2.
- R6: An instruction fetch (ifetch_i=1) in the cache-through or peripheral space reads with size 2 at the address rounded down to a multiple of 4.
- R7: In write-through mode (wb_mode_i=0) a write hit updates the cached bytes selected by size and address. It also issues one bus write at the requested address and size, and is acknowledged with the bus acknowledge.
- R8: In write-back mode (wb_mode_i=1) a write hit is acknowledged with latency 1 and makes no bus beat. Memory keeps its old value until that line leaves the cache.
- R9: A cacheable write miss makes one bus write and allocates no line, so the next read to that line fills it.
- R10: A read miss whose victim line is dirty first writes the four victim longwords at the victim base in increasing order, then performs the fill.
- R11: A flush pulse taken while idle invalidates every line. In write-back mode it writes back each dirty line as four longword writes. Afterwards every read misses and memory holds all data written to the cacheable space.
- R12: ack_o is high for exactly one cycle per request and is never high with no request pending.
- R13: A write to the cache-through or peripheral space goes straight to the bus as one write at the requested address and size. It needs no decode cycle, so with a zero-wait bus the latency is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, held until ack_o |
| we_i | input | 1 | 1 for a write |
| ifetch_i | input | 1 | Request is an instruction fetch |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 longword |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, placed on its byte lanes |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Longword holding the read address, valid with ack_o |
| wb_mode_i | input | 1 | 1 selects write-back, 0 write-through |
| flush_i | input | 1 | Start a flush of all lines |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | Bus beat is a write |
| bus_size_o | output | 2 | Bus beat size, same encoding as size_i |
| bus_addr_o | output | 32 | Bus beat address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus beat completes at this clock edge |
| bus_rdata_i | input | 32 | Bus read data, valid with bus_ack_i |

## Verification
Some rules are checked by the assertions on every cycle: the acknowledge stays a single pulse, fill and write-back beats step by four, a write-back is always followed by a fill from the line base, an uncached read always comes after a decode cycle, and a line is never dirty unless it is valid. Other behaviour can only be shown by the bench scenarios. These are latencies, returned data, the absence of allocation on a write miss, memory staying stale until eviction in write-back mode, and memory matching every processor write after a flush. The bench checks these against a shadow memory under both policies, with random bus wait states.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
  localparam int BEATS  = 4;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LOFF_W = 4;

  typedef enum logic [1:0] {RG_CACHE, RG_THRU, RG_PERIPH} region_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOKUP, S_DECODE, S_BUS_RD, S_BUS_WR,
    S_EVICT, S_FILL, S_FLUSH, S_FLUSH_WB
  } state_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [LANES-1:0] lane_mask(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0:    return 4'b0001 << a;
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/cseq_decode.sv
`timescale 1ns/1ps
module cseq_decode
  import cseq_pkg::*;
(
  input  logic [1:0] sel_i,
  output region_e    region_o
);
  always_comb begin
    case (sel_i)
      2'b00:   region_o = RG_CACHE;
      2'b01:   region_o = RG_THRU;
      default: region_o = RG_PERIPH;
    endcase
  end
endmodule

// File: rtl/cseq_store.sv
`timescale 1ns/1ps
module cseq_store
  import cseq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 25
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W-1:0]        idx_i,
  output logic                    valid_o,
  output logic                    dirty_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [BEATS*WORD_W-1:0] line_o,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_word_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  input  logic                    fill_done_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic                    mark_dirty_i,
  input  logic                    inval_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [WORD_W-1:0] data_q [LINES][BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (inval_i) begin
      valid_q[idx_i] <= 1'b0;
      dirty_q[idx_i] <= 1'b0;
    end else if (fill_done_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_done_i) tag_q[idx_i] <= tag_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_be_i[b]) data_q[idx_i][wr_word_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  for (genvar w = 0; w < BEATS; w++) begin : g_word
    assign line_o[w*WORD_W +: WORD_W] = data_q[idx_i][w];
  end

  for (genvar l = 0; l < LINES; l++) begin : g_chk
    // R8: dirty state exists only on a resident line
    a_r8_dirty_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[l] |-> valid_q[l]);
  end
endmodule

// File: rtl/cseq_ctrl.sv
`timescale 1ns/1ps
module cseq_ctrl
  import cseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W - LOFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic                    ifetch_i,
  input  logic [1:0]              size_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  region_e                 region_i,
  output logic                    ack_o,
  output logic [WORD_W-1:0]       rdata_o,
  input  logic                    wb_mode_i,
  input  logic                    flush_i,
  output logic                    bus_req_o,
  output logic                    bus_we_o,
  output logic [1:0]              bus_size_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [WORD_W-1:0]       bus_wdata_o,
  input  logic                    bus_ack_i,
  input  logic [WORD_W-1:0]       bus_rdata_i,
  output logic [IDX_W-1:0]        st_idx_o,
  input  logic                    st_valid_i,
  input  logic                    st_dirty_i,
  input  logic [TAG_W-1:0]        st_tag_i,
  input  logic [BEATS*WORD_W-1:0] st_line_i,
  output logic                    st_wr_o,
  output logic [1:0]              st_word_o,
  output logic [LANES-1:0]        st_be_o,
  output logic [WORD_W-1:0]       st_wdata_o,
  output logic                    st_fill_done_o,
  output logic [TAG_W-1:0]        st_tag_o,
  output logic                    st_mark_dirty_o,
  output logic                    st_inval_o
);
  state_e            state_q, state_d;
  logic [1:0]        beat_q, beat_d;
  logic [IDX_W-1:0]  fidx_q, fidx_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic              we_q, ifetch_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic              hit, last_beat, flushing, victim_dirty;

  assign req_tag      = addr_q[ADDR_W-1 -: TAG_W];
  assign req_idx      = addr_q[LOFF_W +: IDX_W];
  assign flushing     = (state_q == S_FLUSH) || (state_q == S_FLUSH_WB);
  assign st_idx_o     = flushing ? fidx_q : req_idx;
  assign hit          = st_valid_i && (st_tag_i == req_tag);
  assign last_beat    = (beat_q == 2'd3);
  assign victim_dirty = st_valid_i && st_dirty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      beat_q   <= '0;
      fidx_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      size_q   <= '0;
      we_q     <= 1'b0;
      ifetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      fidx_q  <= fidx_d;
      if (state_q == S_IDLE && req_i && !flush_i) begin
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
        size_q   <= size_i;
        we_q     <= we_i;
        ifetch_q <= ifetch_i;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    fidx_d  = fidx_q;
    case (state_q)
      S_IDLE: begin
        beat_d = '0;
        if (flush_i) begin
          state_d = S_FLUSH;
          fidx_d  = '0;
        end else if (req_i) begin
          if (region_i == RG_CACHE) state_d = S_LOOKUP;
          else if (we_i)            state_d = S_BUS_WR;
          else                      state_d = S_DECODE;
        end
      end
      S_LOOKUP: begin
        beat_d = '0;
        if (hit) begin
          if (!we_q || wb_mode_i) state_d = S_IDLE;
          else                    state_d = S_BUS_WR;
        end else if (we_q) state_d = S_BUS_WR;
        else if (victim_dirty) state_d = S_EVICT;
        else state_d = S_FILL;
      end
      S_DECODE: state_d = S_BUS_RD;
      S_BUS_RD, S_BUS_WR: if (bus_ack_i) state_d = S_IDLE;
      S_EVICT: if (bus_ack_i) begin
        beat_d = beat_q + 2'd1;
        if (last_beat) state_d = S_FILL;
      end
      S_FILL: if (bus_ack_i) begin
        beat_d = beat_q + 2'd1;
        if (last_beat) state_d = S_LOOKUP;
      end
      S_FLUSH: begin
        beat_d = '0;
        if (wb_mode_i && victim_dirty) state_d = S_FLUSH_WB;
        else begin
          fidx_d = fidx_q + IDX_W'(1);
          if (&fidx_q) state_d = S_IDLE;
        end
      end
      S_FLUSH_WB: if (bus_ack_i) begin
        beat_d = beat_q + 2'd1;
        if (last_beat) begin
          fidx_d  = fidx_q + IDX_W'(1);
          state_d = (&fidx_q) ? S_IDLE : S_FLUSH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // bus beat generation
  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_size_o  = SZ_WORD;
    bus_addr_o  = addr_q;
    bus_wdata_o = wdata_q;
    case (state_q)
      S_EVICT, S_FLUSH_WB: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = {st_tag_i, st_idx_o, beat_q, 2'b00};
        bus_wdata_o = st_line_i[beat_q*WORD_W +: WORD_W];
      end
      S_FILL: begin
        bus_req_o  = 1'b1;
        bus_addr_o = {req_tag, req_idx, beat_q, 2'b00};
      end
      S_BUS_RD: begin
        bus_req_o = 1'b1;
        if (ifetch_q) bus_addr_o = {addr_q[ADDR_W-1:2], 2'b00};
        else          bus_size_o = size_q;
      end
      S_BUS_WR: begin
        bus_req_o  = 1'b1;
        bus_we_o   = 1'b1;
        bus_size_o = size_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    ack_o = 1'b0;
    if (state_q == S_LOOKUP && hit && (!we_q || wb_mode_i)) ack_o = 1'b1;
    if ((state_q == S_BUS_RD || state_q == S_BUS_WR) && bus_ack_i) ack_o = 1'b1;
  end

  assign rdata_o = (state_q == S_BUS_RD) ? bus_rdata_i
                                         : st_line_i[addr_q[3:2]*WORD_W +: WORD_W];

  // line store updates
  logic lookup_wr, fill_wr;
  assign lookup_wr = (state_q == S_LOOKUP) && we_q && hit;
  assign fill_wr   = (state_q == S_FILL) && bus_ack_i;

  assign st_wr_o         = lookup_wr || fill_wr;
  assign st_word_o       = fill_wr ? beat_q : addr_q[3:2];
  assign st_be_o         = fill_wr ? {LANES{1'b1}} : lane_mask(size_q, addr_q[1:0]);
  assign st_wdata_o      = fill_wr ? bus_rdata_i : wdata_q;
  assign st_fill_done_o  = fill_wr && last_beat;
  assign st_tag_o        = req_tag;
  assign st_mark_dirty_o = lookup_wr && wb_mode_i;
  assign st_inval_o      = ((state_q == S_FLUSH) && !(wb_mode_i && victim_dirty)) ||
                           ((state_q == S_FLUSH_WB) && bus_ack_i && last_beat);

  a_r12_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r11_flush_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushing |-> !ack_o);

  a_r3_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL && bus_ack_i && !last_beat) |=>
      (bus_req_o && !bus_we_o && bus_addr_o == $past(bus_addr_o) + ADDR_W'(4)));

  a_r10_evict_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EVICT && bus_ack_i && !last_beat) |=>
      (bus_we_o && bus_addr_o == $past(bus_addr_o) + ADDR_W'(4)));

  a_r10_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EVICT && bus_ack_i && last_beat) |=>
      (bus_req_o && !bus_we_o && bus_addr_o[3:0] == 4'd0 && bus_size_o == SZ_WORD));

  a_r5_decode_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BUS_RD && $past(state_q) != S_BUS_RD) |-> $past(state_q) == S_DECODE);
endmodule

// File: rtl/cache_seq.sv
`timescale 1ns/1ps
module cache_seq
  import cseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ifetch_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              wb_mode_i,
  input  logic              flush_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W - LOFF_W;

  region_e                 region;
  logic [IDX_W-1:0]        st_idx;
  logic                    st_valid, st_dirty, st_wr, st_fill_done, st_mark_dirty, st_inval;
  logic [TAG_W-1:0]        st_tag_rd, st_tag_wr;
  logic [BEATS*WORD_W-1:0] st_line;
  logic [1:0]              st_word;
  logic [LANES-1:0]        st_be;
  logic [WORD_W-1:0]       st_wdata;

  cseq_decode i_decode (
    .sel_i    (addr_i[ADDR_W-1 -: 2]),
    .region_o (region)
  );

  cseq_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .ifetch_i, .size_i, .addr_i, .wdata_i,
    .region_i        (region),
    .ack_o, .rdata_o, .wb_mode_i, .flush_i,
    .bus_req_o, .bus_we_o, .bus_size_o, .bus_addr_o, .bus_wdata_o,
    .bus_ack_i, .bus_rdata_i,
    .st_idx_o        (st_idx),
    .st_valid_i      (st_valid),
    .st_dirty_i      (st_dirty),
    .st_tag_i        (st_tag_rd),
    .st_line_i       (st_line),
    .st_wr_o         (st_wr),
    .st_word_o       (st_word),
    .st_be_o         (st_be),
    .st_wdata_o      (st_wdata),
    .st_fill_done_o  (st_fill_done),
    .st_tag_o        (st_tag_wr),
    .st_mark_dirty_o (st_mark_dirty),
    .st_inval_o      (st_inval)
  );

  cseq_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_store (
    .clk_i, .rst_ni,
    .idx_i        (st_idx),
    .valid_o      (st_valid),
    .dirty_o      (st_dirty),
    .tag_o        (st_tag_rd),
    .line_o       (st_line),
    .wr_en_i      (st_wr),
    .wr_word_i    (st_word),
    .wr_be_i      (st_be),
    .wr_data_i    (st_wdata),
    .fill_done_i  (st_fill_done),
    .tag_i        (st_tag_wr),
    .mark_dirty_i (st_mark_dirty),
    .inval_i      (st_inval)
  );
endmodule

// File: tb/test_cache_seq.sv
`timescale 1ns/1ps
module test_cache_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, ifetch_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic        wb_mode_i = 1'b0, flush_i = 1'b0;
  logic        bus_req_o, bus_we_o;
  logic [1:0]  bus_size_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  cache_seq i_cache_seq (.*);

  always #10 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  int wait_max = 0, wcnt = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] shadow [int unsigned];
  int nb = 0;
  logic        lg_we   [16];
  logic [31:0] lg_addr [16];
  logic [1:0]  lg_size [16];
  int pulse_err = 0;

  function automatic logic [31:0] init_val(int unsigned w);
    return (w * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] mem_rd(int unsigned w);
    return mem.exists(w) ? mem[w] : init_val(w);
  endfunction
  function automatic logic [31:0] sh_rd(int unsigned w);
    return shadow.exists(w) ? shadow[w] : init_val(w);
  endfunction
  function automatic logic [31:0] bmask(logic [1:0] sz, logic [1:0] a);
    logic [3:0]  be;
    logic [31:0] m;
    case (sz)
      2'd0:    be = 4'b0001 << a;
      2'd1:    be = a[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // bus slave: decides each beat at the falling edge
  always @(negedge clk_i) begin
    if (!bus_req_o) begin
      bus_ack_i <= 1'b0;
      wcnt = int'($urandom % (wait_max + 1));
    end else if (wcnt > 0) begin
      bus_ack_i <= 1'b0;
      wcnt--;
    end else begin
      int unsigned w;
      logic [31:0] m;
      w = bus_addr_o >> 2;
      m = bmask(bus_size_o, bus_addr_o[1:0]);
      if (bus_we_o) mem[w] = (mem_rd(w) & ~m) | (bus_wdata_o & m);
      bus_rdata_i <= mem_rd(w);
      bus_ack_i   <= 1'b1;
      if (nb < 16) begin
        lg_we[nb] = bus_we_o; lg_addr[nb] = bus_addr_o; lg_size[nb] = bus_size_o;
      end
      nb++;
      wcnt = int'($urandom % (wait_max + 1));
    end
  end

  task automatic step();
    @(posedge clk_i);
    #15;
  endtask

  task automatic access(input bit w, input logic [31:0] a, input logic [1:0] sz,
                        input bit f, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    nb = 0; lat = 0; rd = '0;
    req_i = 1'b1; we_i = w; addr_i = a; size_i = sz; ifetch_i = f; wdata_i = d;
    forever begin
      step();
      lat++;
      if (ack_o) begin rd = rdata_o; break; end
      if (lat > 2000) begin chk(0, "R12", "no ack", 0, 1); break; end
    end
    req_i = 1'b0; we_i = 1'b0; ifetch_i = 1'b0;
    if (w) begin
      int unsigned wi;
      logic [31:0] m;
      wi = a >> 2;
      m = bmask(sz, a[1:0]);
      shadow[wi] = (sh_rd(wi) & ~m) | (d & m);
    end
    step();
    if (ack_o) pulse_err++;
  endtask

  task automatic do_flush();
    nb = 0;
    flush_i = 1'b1;
    step();
    flush_i = 1'b0;
    repeat (200) step();
  endtask

  function automatic bit fill_ok(int first, logic [31:0] base);
    bit ok = 1;
    for (int k = 0; k < 4; k++)
      if (lg_we[first+k] || lg_size[first+k] != 2'd2 || lg_addr[first+k] != base + 32'(4*k)) ok = 0;
    return ok;
  endfunction
  function automatic bit wb_ok(int first, logic [31:0] base);
    bit ok = 1;
    for (int k = 0; k < 4; k++)
      if (!lg_we[first+k] || lg_size[first+k] != 2'd2 || lg_addr[first+k] != base + 32'(4*k)) ok = 0;
    return ok;
  endfunction

  task automatic mem_match(input string req);
    int bad = 0;
    foreach (shadow[k]) if (mem_rd(k) != shadow[k]) bad++;
    chk(bad == 0, req, "memory vs written data mismatches", bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL R12 watchdog expired act=%h exp=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    void'($urandom(32'd1234));
    #5;
    step(); step();
    chk(ack_o == 1'b0, "R12", "ack in reset", ack_o, 0);
    chk(bus_req_o == 1'b0, "R1", "bus idle in reset", bus_req_o, 0);
    rst_ni = 1'b1;
    step();

    // write-through, zero-wait
    access(0, 32'h0000_0108, 2'd2, 0, 0, rd, lat);
    chk(nb == 4 && fill_ok(0, 32'h100), "R3", "miss fill beats", nb, 4);
    chk(rd == sh_rd(32'h108 >> 2), "R3", "miss data", rd, sh_rd(32'h108 >> 2));
    access(0, 32'h0000_010C, 2'd2, 0, 0, rd, lat);
    chk(lat == 1 && nb == 0, "R2", "hit latency/no bus", lat, 1);
    chk(rd == sh_rd(32'h10C >> 2), "R2", "hit data", rd, sh_rd(32'h10C >> 2));
    access(0, 32'h0000_0213, 2'd0, 0, 0, rd, lat);
    chk(nb == 4 && fill_ok(0, 32'h210), "R4", "byte miss longword fill", lg_addr[0], 32'h210);
    access(0, 32'h0000_0322, 2'd1, 1, 0, rd, lat);
    chk(nb == 4 && fill_ok(0, 32'h320), "R4", "4n+2 fetch fill", lg_addr[0], 32'h320);
    chk(rd == sh_rd(32'h320 >> 2), "R4", "4n+2 fetch data", rd, sh_rd(32'h320 >> 2));
    access(0, 32'h4000_0012, 2'd1, 0, 0, rd, lat);
    chk(lat == 2 && nb == 1 && lg_addr[0] == 32'h4000_0012 && lg_size[0] == 2'd1,
        "R5", "through read decode cycle", lat, 2);
    chk(rd == sh_rd(32'h4000_0010 >> 2), "R5", "through data", rd, sh_rd(32'h4000_0010 >> 2));
    access(0, 32'h8000_0020, 2'd2, 0, 0, rd, lat);
    chk(lat == 2 && nb == 1 && lg_addr[0] == 32'h8000_0020, "R1", "peripheral read", lat, 2);
    access(0, 32'h4000_0022, 2'd1, 1, 0, rd, lat);
    chk(nb == 1 && lg_size[0] == 2'd2 && lg_addr[0] == 32'h4000_0020, "R6", "through fetch size", lg_addr[0], 32'h4000_0020);
    access(1, 32'h0000_0109, 2'd0, 0, 32'h0000_A500, rd, lat);
    chk(lat == 2 && nb == 1 && lg_we[0] && lg_addr[0] == 32'h109 && lg_size[0] == 2'd0,
        "R7", "write-through hit bus write", lat, 2);
    access(0, 32'h0000_0108, 2'd2, 0, 0, rd, lat);
    chk(lat == 1 && rd == sh_rd(32'h108 >> 2), "R7", "cached bytes updated", rd, sh_rd(32'h108 >> 2));
    access(1, 32'h0000_0500, 2'd2, 0, 32'h1234_5678, rd, lat);
    chk(nb == 1 && lg_we[0], "R9", "write miss single write", nb, 1);
    access(0, 32'h0000_0500, 2'd2, 0, 0, rd, lat);
    chk(nb == 4 && fill_ok(0, 32'h500), "R9", "no allocation on write miss", nb, 4);
    chk(rd == 32'h1234_5678, "R9", "data after write miss", rd, 32'h1234_5678);
    access(1, 32'h4000_0030, 2'd2, 0, 32'hDEAD_0001, rd, lat);
    chk(lat == 1 && nb == 1 && lg_addr[0] == 32'h4000_0030, "R13", "through write", lat, 1);
    access(1, 32'hC000_0006, 2'd1, 0, 32'hBEEF_0000, rd, lat);
    chk(lat == 1 && nb == 1 && lg_size[0] == 2'd1, "R13", "peripheral write", lat, 1);

    // flush then write-back
    do_flush();
    chk(nb == 0, "R11", "clean flush no beats", nb, 0);
    wb_mode_i = 1'b1;
    access(0, 32'h0000_0100, 2'd2, 0, 0, rd, lat);
    chk(nb == 4, "R11", "read misses after flush", nb, 4);
    access(1, 32'h0000_0104, 2'd2, 0, 32'hCAFE_F00D, rd, lat);
    chk(lat == 1 && nb == 0, "R8", "write-back hit no bus", lat, 1);
    chk(mem_rd(32'h104 >> 2) != 32'hCAFE_F00D, "R8", "memory stale before evict", mem_rd(32'h104 >> 2), 0);
    access(0, 32'h0000_0188, 2'd2, 0, 0, rd, lat);
    chk(nb == 8 && wb_ok(0, 32'h100) && fill_ok(4, 32'h180), "R10", "evict then fill", nb, 8);
    chk(mem_rd(32'h104 >> 2) == 32'hCAFE_F00D, "R10", "victim written back", mem_rd(32'h104 >> 2), 32'hCAFE_F00D);
    chk(rd == sh_rd(32'h188 >> 2), "R10", "data after evict", rd, sh_rd(32'h188 >> 2));
    access(1, 32'h0000_0184, 2'd2, 0, 32'h0BAD_CAFE, rd, lat);
    do_flush();
    chk(nb == 4 && wb_ok(0, 32'h180), "R11", "dirty flush write-back", nb, 4);
    access(0, 32'h0000_0184, 2'd2, 0, 0, rd, lat);
    chk(nb == 4 && rd == 32'h0BAD_CAFE, "R11", "refill after flush", rd, 32'h0BAD_CAFE);

    // random phases, both policies, random waits
    wait_max = 2;
    for (int ph = 0; ph < 4; ph++) begin
      int bad = 0;
      wb_mode_i = ph[0];
      for (int n = 0; n < 250; n++) begin
        int unsigned r;
        logic [31:0] a;
        logic [1:0]  sz;
        bit w, f;
        r = $urandom % 10;
        if (r < 6)      a = (($urandom % 4) << 7) | (($urandom % 8) << 4) | (($urandom % 4) << 2);
        else if (r < 8) a = 32'h4000_0000 | (($urandom % 32) << 2);
        else            a = 32'h8000_0000 | (($urandom % 32) << 2);
        w  = ($urandom % 3) == 0;
        sz = 2'($urandom % 3);
        if (sz == 2'd1) a = a | (($urandom % 2) << 1);
        if (sz == 2'd0) a = a | ($urandom % 4);
        f  = !w && (($urandom % 4) == 0);
        access(w, a, sz, f, $urandom, rd, lat);
        if (!w && rd != sh_rd(a >> 2)) begin
          bad++;
          $display("FAIL R3 random read at %h act=%h exp=%h", a, rd, sh_rd(a >> 2));
        end
      end
      chk(bad == 0, "R2", "random read mismatches", bad, 0);
      do_flush();
      mem_match("R11");
    end
    chk(pulse_err == 0, "R12", "ack longer than one cycle", pulse_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule